// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers five interrupt request lines and chooses which one the processor core takes next. One line is non-maskable and ranks above everything else. Three restart lines follow in fixed descending rank, and each carries a hard-wired vector address. The last is a general request whose vector the core obtains from outside through an active-low acknowledge.

The core signals each instruction boundary with a strobe. Only on that strobe does the controller pick a winner. It then raises a request toward the core and presents the winner's vector and a one-hot source code. These hold until the core returns a service-taken strobe.

The controller keeps a global enable flag, which the core sets and clears with strobes. Any acceptance clears the flag. The top restart line captures rising edges. The two lower restart lines and the general request follow their level. The non-maskable line needs a rising edge that is still held high when the boundary arrives.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_o`=0, `inta_n_o`=1, `ie_o`=0, `src_o`=0 and `vec_o`=0.
- R2: When several sources are eligible at a boundary, the winner follows this order: non-maskable, then restart-hi, then restart-mid, then restart-lo, then the general request. `src_o` is one-hot with bit 0 for non-maskable, bit 1 for restart-hi, bit 2 for restart-mid, bit 3 for restart-lo and bit 4 for general.
- R3: The non-maskable source is accepted whether `ie_o` is 0 or 1 and whatever `mask_i` holds.
- R4: The other four sources are accepted only while `ie_o`=1. A restart line is also blocked while its mask bit is 1: `mask_i[2]` blocks restart-hi, `mask_i[1]` blocks restart-mid and `mask_i[0]` blocks restart-lo.
- R5: `vec_o` is 0x0024 for non-maskable, 0x003C for restart-hi, 0x0034 for restart-mid, 0x002C for restart-lo and 0x0000 for the general request.
- R6: A rising edge on restart-hi is remembered after the line falls again, until it is accepted. A line held high after acceptance does not request again without a new edge.
- R7: Restart-mid, restart-lo and the general request are level sensitive. A level that falls before the boundary is not accepted.
- R8: The non-maskable source needs a rising edge with the line still high at the boundary. A pulse that has ended is not accepted, and a line held high after acceptance does not request again.
- R9: `inta_n_o` goes low only when the general request is accepted, and returns high when `svc_i` arrives.
- R10: `ie_set_i` sets `ie_o` and `ie_clr_i` clears it. Any acceptance clears it, and acceptance wins over a set in the same cycle.
- R11: Acceptance happens only on a cycle with `boundary_i`=1 and no outstanding request. While `irq_o`=1, the source and vector hold until `svc_i`.
- R12: `clr_hi_i` discards a remembered restart-hi edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request line |
| rhi_i | input | 1 | Restart-hi request (edge) |
| rmid_i | input | 1 | Restart-mid request (level) |
| rlo_i | input | 1 | Restart-lo request (level) |
| gen_i | input | 1 | General request (level) |
| mask_i | input | 3 | Restart masks: [2] hi, [1] mid, [0] lo |
| ie_set_i | input | 1 | Set global enable |
| ie_clr_i | input | 1 | Clear global enable |
| clr_hi_i | input | 1 | Discard remembered restart-hi edge |
| boundary_i | input | 1 | Instruction boundary strobe |
| svc_i | input | 1 | Service-taken strobe from core |
| irq_o | output | 1 | Request to core |
| vec_o | output | 16 | Restart vector address |
| src_o | output | 5 | One-hot accepted source |
| inta_n_o | output | 1 | Active-low acknowledge for general request |
| ie_o | output | 1 | Global enable state |

## Verification
On the clock edge that samples `boundary_i`, the controller registers `irq_o`, `vec_o`, `src_o`, `inta_n_o` and the cleared `ie_o` together. The bench reads them at the next falling edge. The edge-captured lines need one further edge to latch, so the bench raises them at least one cycle before the boundary strobe. `svc_i` and the enable strobes take effect one edge after they are driven. A scoreboard queue receives the expected source, vector and acknowledge before each strobe, and a monitor compares them on every rising `irq_o`. "Nothing accepted" cases are sampled at the same falling edge that follows the strobe.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 5;
  localparam int NRST   = 3;
  localparam int I_NMI  = 0;
  localparam int I_RHI  = 1;
  localparam int I_RMID = 2;
  localparam int I_RLO  = 3;
  localparam int I_GEN  = 4;
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_i,
  input  logic            rhi_i,
  input  logic            rmid_i,
  input  logic            rlo_i,
  input  logic            gen_i,
  input  logic            nmi_take,
  input  logic            rhi_drop,
  output logic [NSRC-1:0] pend
);
  logic nmi_prev_q, nmi_lat_q, rhi_prev_q, rhi_lat_q;
  logic nmi_lat_d, rhi_lat_d;

  always_comb begin
    nmi_lat_d = nmi_lat_q;
    if (!nmi_i || nmi_take)        nmi_lat_d = 1'b0;
    else if (!nmi_prev_q)          nmi_lat_d = 1'b1;
    rhi_lat_d = rhi_lat_q;
    if (rhi_i && !rhi_prev_q)      rhi_lat_d = 1'b1;
    else if (rhi_drop)             rhi_lat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b1;
      rhi_prev_q <= 1'b1;
      nmi_lat_q  <= 1'b0;
      rhi_lat_q  <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_i;
      rhi_prev_q <= rhi_i;
      nmi_lat_q  <= nmi_lat_d;
      rhi_lat_q  <= rhi_lat_d;
    end
  end

  always_comb begin
    pend         = '0;
    pend[I_NMI]  = nmi_lat_q & nmi_i;
    pend[I_RHI]  = rhi_lat_q;
    pend[I_RMID] = rmid_i;
    pend[I_RLO]  = rlo_i;
    pend[I_GEN]  = gen_i;
  end

  // R8: a dropped non-maskable line never shows as pending
  p_nmi_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_i |-> !pend[I_NMI]);
  // R6: a captured restart-hi edge survives the line falling
  p_rhi_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend[I_RHI] && !rhi_drop |=> pend[I_RHI]);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_rank
    assign grant[i]   = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end
  assign any = taken[N];
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] VEC_NMI  = 16'h0024,
  parameter logic [15:0] VEC_RHI  = 16'h003C,
  parameter logic [15:0] VEC_RMID = 16'h0034,
  parameter logic [15:0] VEC_RLO  = 16'h002C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic              rhi_i,
  input  logic              rmid_i,
  input  logic              rlo_i,
  input  logic              gen_i,
  input  logic [NRST-1:0]   mask_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic              clr_hi_i,
  input  logic              boundary_i,
  input  logic              svc_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [NSRC-1:0]   src_o,
  output logic              inta_n_o,
  output logic              ie_o
);
  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic [NSRC-1:0]   raw, elig, grant, src_q, src_d;
  logic [ADDR_W-1:0] vec_q, vec_d, vec_sel;
  logic              any, accept;
  logic              irq_q, irq_d, ie_q, ie_d, inta_q, inta_d;

  irq_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .nmi_i    (nmi_i),
    .rhi_i    (rhi_i),
    .rmid_i   (rmid_i),
    .rlo_i    (rlo_i),
    .gen_i    (gen_i),
    .nmi_take (accept & grant[I_NMI]),
    .rhi_drop (clr_hi_i | (accept & grant[I_RHI])),
    .pend     (raw)
  );

  always_comb begin
    elig         = raw;
    elig[I_RHI]  = raw[I_RHI]  & ie_q & ~mask_i[2];
    elig[I_RMID] = raw[I_RMID] & ie_q & ~mask_i[1];
    elig[I_RLO]  = raw[I_RLO]  & ie_q & ~mask_i[0];
    elig[I_GEN]  = raw[I_GEN]  & ie_q;
  end

  irq_arbiter #(.N(NSRC)) u_arb (
    .req   (elig),
    .grant (grant),
    .any   (any)
  );

  always_comb begin
    vec_sel = '0;
    if (grant[I_NMI])  vec_sel = VEC_NMI[ADDR_W-1:0];
    if (grant[I_RHI])  vec_sel = VEC_RHI[ADDR_W-1:0];
    if (grant[I_RMID]) vec_sel = VEC_RMID[ADDR_W-1:0];
    if (grant[I_RLO])  vec_sel = VEC_RLO[ADDR_W-1:0];
  end

  assign accept = boundary_i & ~irq_q & any;

  always_comb begin
    irq_d  = irq_q;
    src_d  = src_q;
    vec_d  = vec_q;
    inta_d = inta_q;
    ie_d   = ie_q;
    if (ie_set_i)      ie_d = 1'b1;
    else if (ie_clr_i) ie_d = 1'b0;
    if (accept) begin
      irq_d  = 1'b1;
      src_d  = grant;
      vec_d  = vec_sel;
      inta_d = ~grant[I_GEN];
      ie_d   = 1'b0;
    end else if (svc_i && irq_q) begin
      irq_d  = 1'b0;
      src_d  = '0;
      vec_d  = '0;
      inta_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      irq_q  <= 1'b0;
      src_q  <= '0;
      vec_q  <= '0;
      inta_q <= 1'b1;
      ie_q   <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      src_q  <= src_d;
      vec_q  <= vec_d;
      inta_q <= inta_d;
      ie_q   <= ie_d;
    end
  end

  assign irq_o    = irq_q;
  assign src_o    = src_q;
  assign vec_o    = vec_q;
  assign inta_n_o = inta_q;
  assign ie_o     = ie_q;

  p_src_onehot_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(src_q) && (irq_q == (src_q != '0)));
  p_nmi_ignores_ie_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    boundary_i && !irq_q && raw[I_NMI] |=> irq_q && src_q[I_NMI]);
  p_disabled_blocks_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    boundary_i && !irq_q && !ie_q && !raw[I_NMI] |=> !irq_q);
  p_inta_gen_only_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !inta_q |-> irq_q && src_q[I_GEN]);
  p_accept_clears_ie_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(irq_q) |-> !ie_q);
  p_no_eval_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    !boundary_i && !irq_q |=> !irq_q);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_q && !svc_i |=> irq_q && $stable(vec_q) && $stable(src_q));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic nmi, rhi, rmid, rlo, gen, ie_set, ie_clr, clr_hi, bnd, svc;
  logic [2:0]  mask;
  logic        irq_o, inta_n_o, ie_o;
  logic [15:0] vec_o;
  logic [4:0]  src_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .rhi_i(rhi), .rmid_i(rmid),
    .rlo_i(rlo), .gen_i(gen), .mask_i(mask), .ie_set_i(ie_set),
    .ie_clr_i(ie_clr), .clr_hi_i(clr_hi), .boundary_i(bnd), .svc_i(svc),
    .irq_o(irq_o), .vec_o(vec_o), .src_o(src_o), .inta_n_o(inta_n_o),
    .ie_o(ie_o)
  );

  typedef struct {
    logic [4:0]  src;
    logic [15:0] vec;
    logic        inta_n;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (sb.size() != 0) chk(1'b0, "R2 scoreboard leftover", sb.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic push(input logic [4:0] s, input logic [15:0] v, input string t);
    exp_t e;
    e.src = s; e.vec = v; e.inta_n = ~s[4]; e.tag = t;
    sb.push_back(e);
  endtask
  task automatic boundary(); bnd = 1'b1; tick(); bnd = 1'b0; endtask
  task automatic serve();
    svc = 1'b1; tick(); svc = 1'b0;
    chk(irq_o == 1'b0 && inta_n_o == 1'b1, "R9 serve drops request", {irq_o, inta_n_o}, 1);
  endtask
  task automatic en(); ie_set = 1'b1; tick(); ie_set = 1'b0; endtask
  task automatic idle(input string t); chk(irq_o == 1'b0, t, irq_o, 0); endtask

  // monitor: compare on each rising request
  logic seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_o && !seen) begin
        if (sb.size() == 0) chk(1'b0, "R11 unexpected request", src_o, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(src_o == e.src, {e.tag, " src"}, src_o, e.src);
          chk(vec_o == e.vec, {e.tag, " vec"}, vec_o, e.vec);
          chk(inta_n_o == e.inta_n, {e.tag, " inta"}, inta_n_o, e.inta_n);
        end
      end
      seen = irq_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    {nmi, rhi, rmid, rlo, gen, ie_set, ie_clr, clr_hi, bnd, svc} = '0;
    mask = 3'b111;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    // R1
    chk(irq_o == 0 && inta_n_o == 1 && ie_o == 0 && src_o == 0 && vec_o == 0,
        "R1 reset state", {irq_o, inta_n_o, ie_o, src_o}, 5'b0 | 8'h40);

    // R3: non-maskable with enable off and all masks set
    nmi = 1'b1; tick();
    push(5'b00001, 16'h0024, "R3 R5 nmi");
    boundary();
    serve();
    // R8: held high, no new edge
    boundary(); idle("R8 nmi held no retrigger");
    nmi = 1'b0; tick();
    // R8: pulse gone before boundary
    nmi = 1'b1; tick(); nmi = 1'b0; tick();
    boundary(); idle("R8 nmi pulse ended");

    // R4: enable off blocks restart-mid
    rmid = 1'b1; tick();
    boundary(); idle("R4 enable off");
    en(); chk(ie_o == 1'b1, "R10 set enable", ie_o, 1);
    boundary(); idle("R4 masked mid");
    mask = 3'b101;
    push(5'b00100, 16'h0034, "R4 R5 mid");
    boundary();
    chk(ie_o == 1'b0, "R10 accept clears enable", ie_o, 0);
    serve();
    rmid = 1'b0; mask = 3'b000;

    // R10: clear strobe
    en(); ie_clr = 1'b1; tick(); ie_clr = 1'b0;
    chk(ie_o == 1'b0, "R10 clear enable", ie_o, 0);

    // R2: priority chain
    en();
    rhi = 1'b1; rmid = 1'b1; rlo = 1'b1; gen = 1'b1; tick(); rhi = 1'b0; tick();
    push(5'b00010, 16'h003C, "R2 R6 hi first"); boundary(); serve(); en();
    push(5'b00100, 16'h0034, "R2 mid second");  boundary(); serve(); en();
    rmid = 1'b0;
    push(5'b01000, 16'h002C, "R2 R7 lo third"); boundary(); serve(); en();
    rlo = 1'b0;
    push(5'b10000, 16'h0000, "R2 R9 gen last"); boundary();
    chk(inta_n_o == 1'b0, "R9 ack low for general", inta_n_o, 0);
    serve(); gen = 1'b0;

    // R11: no boundary, no acceptance; hold while outstanding
    en(); rlo = 1'b1;
    repeat (3) tick();
    idle("R11 no strobe");
    push(5'b01000, 16'h002C, "R11 lo"); boundary();
    nmi = 1'b1; tick(); boundary();
    chk(src_o == 5'b01000 && vec_o == 16'h002C, "R11 held while outstanding", src_o, 5'b01000);
    serve();
    push(5'b00001, 16'h0024, "R11 nmi after serve"); boundary(); serve();
    nmi = 1'b0; rlo = 1'b0; tick();

    // R12: discard remembered hi edge
    en(); rhi = 1'b1; tick(); rhi = 1'b0; clr_hi = 1'b1; tick(); clr_hi = 1'b0;
    boundary(); idle("R12 cleared edge");

    // R7: level dropped before boundary
    rmid = 1'b1; tick(); rmid = 1'b0; tick();
    boundary(); idle("R7 mid level gone");

    // R6: held high after acceptance
    rhi = 1'b1; tick();
    push(5'b00010, 16'h003C, "R6 hi edge"); boundary(); serve(); en();
    boundary(); idle("R6 hi held no retrigger");
    rhi = 1'b0;
    repeat (2) tick();
    finish_up();
  end
endmodule